// File: doc/BRIEF.md
# Coarse-Grain Thread Switch Controller

This block selects which of several hardware thread contexts feeds one in-order pipeline. Exactly one thread issues at a time, so the pipeline otherwise runs as a plain single-thread machine. The controller holds a program counter and a ready flag for each context. It gives the fetch unit the active thread number, a fetch valid strobe and the fetch address. The active thread stays in place until it takes an instruction-cache or data-cache miss. Ordinary hazard stalls never move execution to another thread.

On an instruction-cache miss, the fetch-stage instruction is killed. The thread's PC stays on the missing address, the thread is marked not ready, and the next ready thread takes over on the following cycle. On a data-cache miss, the pipeline reports the faulting thread, its stage and its PC. The controller kills that instruction and every younger instruction of the same thread that is still in flight. It rewinds that thread's PC to the faulting address and parks the thread. A fill-complete indication makes a parked thread eligible again. While no thread is ready, fetch stalls.

Top module: `cgts_switch_ctrl`

## Requirements
- R1: While reset is held, the outputs are: active thread 0, fetch valid high, fetch PC equal to the base reset address, and no kills. Thread t starts at the base address plus t times the reset stride, and every thread starts ready.
- R2: If fetch is valid, the pipeline accepts the fetch and no miss is signalled, then one cycle later the same thread is active and the fetch PC has grown by the PC increment.
- R3: If fetch is valid, the pipeline holds off fetch and no miss is signalled, then the active thread and the fetch PC stay unchanged.
- R4: A fetch-side miss while fetch is valid kills stage 0 in the same cycle. It parks the active thread with its PC kept at the missing address, and the thread does not fetch in the next cycle.
- R5: A data miss asserts kill bit s, in the same cycle, exactly for the stages that meet all three conditions: the stage is valid, its thread tag equals the missing thread, and s is no greater than the missing stage. Stage 0 is fetch, and a higher index holds an older instruction. With no miss, no kill bit is asserted.
- R6: A data miss loads the missing thread's PC with the faulting address and parks the thread. When the thread resumes, fetch restarts at that address.
- R7: When the active thread is parked, the next thread is the first ready one found by counting upward from the current number with wrap-around. The switch takes effect one cycle after the miss.
- R8: When no thread is ready, fetch valid stays low and the active thread is held until a fill-complete arrives. The cycle after that, the filled thread becomes active.
- R9: A fill-complete for a thread makes it ready again, and it does not displace an active thread that is still ready.
- R10: If a fetch-side miss and a data miss hit the same thread in one cycle, the thread's PC takes the data-miss address. If a miss and a fill-complete name the same thread in one cycle, the thread ends not ready.
- R11: The active thread changes only after a miss on it, or while it is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_adv | input | 1 | Pipeline accepts the current fetch |
| ic_miss_vld | input | 1 | Fetch-stage instruction missed the instruction cache |
| ic_miss_pc | input | PC_W | Address of the instruction that missed on fetch |
| dc_miss_vld | input | 1 | A memory instruction missed the data cache |
| dc_miss_tid | input | TID_W | Thread of the data-missing instruction |
| dc_miss_stg | input | STG_W | Stage index holding the data-missing instruction |
| dc_miss_pc | input | PC_W | Address of the data-missing instruction |
| fill_done_vld | input | 1 | An outstanding miss has been served |
| fill_done_tid | input | TID_W | Thread whose miss has been served |
| stg_vld | input | NSTG | Per-stage occupancy |
| stg_tid | input | NSTG*TID_W | Per-stage thread tag, stage s at bits s*TID_W upward |
| act_tid | output | TID_W | Active thread |
| fetch_vld | output | 1 | Active thread may fetch |
| fetch_pc | output | PC_W | Fetch address of the active thread |
| kill | output | NSTG | Per-stage squash |

## Verification
The main function is driven with runs of plain advancing fetch and hazard hold-offs, which separate PC stepping from holding. Fetch misses and data misses at several stages are applied with mixed thread tags in the pipe, including an older instruction of the missing thread. This shows that kills stop at the miss age and follow the thread tag, not stage position alone. Miss sequences that park threads one after another exercise wrap-around selection, the all-parked stall and resumption at the rewound address. Same-cycle collisions of the two miss kinds, and of a miss with a fill, pin down the precedence rules.

// File: rtl/cgts_pkg.sv
package cgts_pkg;

  // Modular step used by the thread picker: base is below n, off is at most n.
  function automatic int wrap_add(input int base, input int off, input int n);
    int s;
    s = base + off;
    if (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/cgts_ctx.sv
// One thread context: program counter and ready flag.
module cgts_ctx #(
  parameter int                PC_W   = 32,
  parameter int                PC_INC = 4,
  parameter logic [PC_W-1:0]   RST_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [PC_W-1:0] load_pc,
  input  logic            adv_en,
  input  logic            clr_rdy,
  input  logic            set_rdy,
  output logic [PC_W-1:0] pc_o,
  output logic            rdy_o,
  output logic            rdy_nxt_o
);

  logic [PC_W-1:0] pc_q, pc_d;
  logic            pc_en;
  logic            rdy_q, rdy_d;

  always_comb begin
    pc_d  = pc_q;
    pc_en = 1'b0;
    if (load_en) begin
      pc_d  = load_pc;
      pc_en = 1'b1;
    end else if (adv_en) begin
      pc_d  = pc_q + PC_W'(PC_INC);
      pc_en = 1'b1;
    end
    rdy_d = rdy_q;
    if (set_rdy) rdy_d = 1'b1;
    if (clr_rdy) rdy_d = 1'b0;   // a new miss outranks a fill
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RST_PC;
      rdy_q <= 1'b1;
    end else begin
      if (pc_en) pc_q <= pc_d;
      rdy_q <= rdy_d;
    end
  end

  assign pc_o      = pc_q;
  assign rdy_o     = rdy_q;
  assign rdy_nxt_o = rdy_d;

endmodule

// File: rtl/cgts_pick.sv
// Finds the first ready thread above the current one, wrapping around.
module cgts_pick
  import cgts_pkg::*;
#(
  parameter int NTHR  = 4,
  parameter int TID_W = 2
) (
  input  logic [NTHR-1:0]  rdy_i,
  input  logic [TID_W-1:0] cur_i,
  output logic             found_o,
  output logic [TID_W-1:0] pick_o
);

  always_comb begin
    logic [TID_W-1:0] idx;
    found_o = 1'b0;
    pick_o  = cur_i;
    for (int off = 1; off <= NTHR; off++) begin
      idx = TID_W'(wrap_add(int'(cur_i), off, NTHR));
      if (!found_o && rdy_i[idx]) begin
        found_o = 1'b1;
        pick_o  = idx;
      end
    end
  end

endmodule

// File: rtl/cgts_kill.sv
// Per-stage squash: missing thread's instructions at or younger than the miss.
module cgts_kill #(
  parameter int NSTG  = 5,
  parameter int TID_W = 2,
  parameter int STG_W = 3
) (
  input  logic                  ic_hit_i,
  input  logic                  dc_vld_i,
  input  logic [TID_W-1:0]      dc_tid_i,
  input  logic [STG_W-1:0]      dc_stg_i,
  input  logic [NSTG-1:0]       stg_vld_i,
  input  logic [NSTG*TID_W-1:0] stg_tid_i,
  output logic [NSTG-1:0]       kill_o
);

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    logic [TID_W-1:0] tag;
    logic             dc_hit;
    assign tag    = stg_tid_i[s*TID_W +: TID_W];
    assign dc_hit = dc_vld_i && stg_vld_i[s] && (tag == dc_tid_i)
                    && (STG_W'(s) <= dc_stg_i);
    if (s == 0) begin : g_fetch
      assign kill_o[s] = dc_hit || ic_hit_i;
    end else begin : g_back
      assign kill_o[s] = dc_hit;
    end
  end

endmodule

// File: rtl/cgts_switch_ctrl.sv
module cgts_switch_ctrl #(
  parameter int              NTHR        = 4,
  parameter int              NSTG        = 5,
  parameter int              PC_W        = 32,
  parameter int              PC_INC      = 4,
  parameter logic [PC_W-1:0] RST_PC_BASE = 'h1000,
  parameter logic [PC_W-1:0] RST_PC_STEP = 'h100,
  localparam int             TID_W       = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int             STG_W       = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fetch_adv,
  input  logic                  ic_miss_vld,
  input  logic [PC_W-1:0]       ic_miss_pc,
  input  logic                  dc_miss_vld,
  input  logic [TID_W-1:0]      dc_miss_tid,
  input  logic [STG_W-1:0]      dc_miss_stg,
  input  logic [PC_W-1:0]       dc_miss_pc,
  input  logic                  fill_done_vld,
  input  logic [TID_W-1:0]      fill_done_tid,
  input  logic [NSTG-1:0]       stg_vld,
  input  logic [NSTG*TID_W-1:0] stg_tid,
  output logic [TID_W-1:0]      act_tid,
  output logic                  fetch_vld,
  output logic [PC_W-1:0]       fetch_pc,
  output logic [NSTG-1:0]       kill
);

  logic [TID_W-1:0] act_q;
  logic             act_en;
  logic [PC_W-1:0]  pc_vec [NTHR];
  logic [NTHR-1:0]  rdy_q, rdy_d;
  logic [NTHR-1:0]  ld_en, adv_en, set_rdy;
  logic [PC_W-1:0]  ld_pc [NTHR];
  logic             ic_hit;
  logic             pick_found;
  logic [TID_W-1:0] pick_tid;

  assign fetch_vld = rdy_q[act_q];
  assign fetch_pc  = pc_vec[act_q];
  assign act_tid   = act_q;
  assign ic_hit    = ic_miss_vld && fetch_vld;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic dc_mine, ic_mine;
    assign dc_mine    = dc_miss_vld && (dc_miss_tid == TID_W'(t));
    assign ic_mine    = ic_hit && (act_q == TID_W'(t));
    assign ld_en[t]   = dc_mine || ic_mine;
    assign ld_pc[t]   = dc_mine ? dc_miss_pc : ic_miss_pc;  // older miss wins
    assign adv_en[t]  = (act_q == TID_W'(t)) && fetch_vld && fetch_adv && !ic_hit;
    assign set_rdy[t] = fill_done_vld && (fill_done_tid == TID_W'(t));

    cgts_ctx #(
      .PC_W   (PC_W),
      .PC_INC (PC_INC),
      .RST_PC (RST_PC_BASE + PC_W'(t) * RST_PC_STEP)
    ) u_ctx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (ld_en[t]),
      .load_pc   (ld_pc[t]),
      .adv_en    (adv_en[t]),
      .clr_rdy   (ld_en[t]),
      .set_rdy   (set_rdy[t]),
      .pc_o      (pc_vec[t]),
      .rdy_o     (rdy_q[t]),
      .rdy_nxt_o (rdy_d[t])
    );
  end

  cgts_pick #(
    .NTHR  (NTHR),
    .TID_W (TID_W)
  ) u_pick (
    .rdy_i   (rdy_d),
    .cur_i   (act_q),
    .found_o (pick_found),
    .pick_o  (pick_tid)
  );

  cgts_kill #(
    .NSTG  (NSTG),
    .TID_W (TID_W),
    .STG_W (STG_W)
  ) u_kill (
    .ic_hit_i  (ic_hit),
    .dc_vld_i  (dc_miss_vld),
    .dc_tid_i  (dc_miss_tid),
    .dc_stg_i  (dc_miss_stg),
    .stg_vld_i (stg_vld),
    .stg_tid_i (stg_tid),
    .kill_o    (kill)
  );

  // Switch only when the active thread will not be ready next cycle.
  always_comb begin
    act_en = !rdy_d[act_q] && pick_found;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (act_en) begin
      act_q <= pick_tid;
    end
  end

endmodule

// File: rtl/cgts_switch_ctrl_chk.sv
module cgts_switch_ctrl_chk #(
  parameter int NTHR   = 4,
  parameter int NSTG   = 5,
  parameter int PC_W   = 32,
  parameter int PC_INC = 4,
  localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int STG_W = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  fetch_adv,
  input logic                  ic_miss_vld,
  input logic                  dc_miss_vld,
  input logic [TID_W-1:0]      dc_miss_tid,
  input logic [STG_W-1:0]      dc_miss_stg,
  input logic                  fill_done_vld,
  input logic [NSTG-1:0]       stg_vld,
  input logic [NSTG*TID_W-1:0] stg_tid,
  input logic [TID_W-1:0]      act_tid,
  input logic                  fetch_vld,
  input logic [PC_W-1:0]       fetch_pc,
  input logic [NSTG-1:0]       kill
);

  p_adv_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld && fetch_adv && !ic_miss_vld && !dc_miss_vld
    |=> (fetch_pc == $past(fetch_pc) + PC_W'(PC_INC)) && (act_tid == $past(act_tid)));

  p_hazard_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld && !fetch_adv && !ic_miss_vld && !dc_miss_vld
    |=> $stable(act_tid) && $stable(fetch_pc));

  p_imiss_leave_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld && ic_miss_vld |=> (act_tid != $past(act_tid)) || !fetch_vld);

  p_quiet_kill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ic_miss_vld && !dc_miss_vld |-> kill == '0);

  for (genvar s = 0; s < NSTG; s++) begin : g_kchk
    p_kill_scope_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dc_miss_vld && !ic_miss_vld && kill[s]
      |-> stg_vld[s] && (stg_tid[s*TID_W +: TID_W] == dc_miss_tid)
          && (STG_W'(s) <= dc_miss_stg));
    p_kill_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dc_miss_vld && stg_vld[s] && (stg_tid[s*TID_W +: TID_W] == dc_miss_tid)
      && (STG_W'(s) <= dc_miss_stg) |-> kill[s]);
  end

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_vld && !fill_done_vld |=> !fetch_vld && $stable(act_tid));

  p_no_switch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld && !ic_miss_vld && !(dc_miss_vld && (dc_miss_tid == act_tid))
    |=> act_tid == $past(act_tid));

endmodule

bind cgts_switch_ctrl cgts_switch_ctrl_chk #(
  .NTHR   (NTHR),
  .NSTG   (NSTG),
  .PC_W   (PC_W),
  .PC_INC (PC_INC)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetch_adv     (fetch_adv),
  .ic_miss_vld   (ic_miss_vld),
  .dc_miss_vld   (dc_miss_vld),
  .dc_miss_tid   (dc_miss_tid),
  .dc_miss_stg   (dc_miss_stg),
  .fill_done_vld (fill_done_vld),
  .stg_vld       (stg_vld),
  .stg_tid       (stg_tid),
  .act_tid       (act_tid),
  .fetch_vld     (fetch_vld),
  .fetch_pc      (fetch_pc),
  .kill          (kill)
);

// File: tb/cgts_switch_ctrl_bench.sv
module cgts_switch_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV         = 14;

  typedef struct packed {
    logic        adv;
    logic        ic;
    logic        dc;
    logic [1:0]  dtid;
    logic [2:0]  dstg;
    logic [31:0] mpc;
    logic        done;
    logic [1:0]  ftid;
    logic [4:0]  svld;
    logic [9:0]  stid;
    logic [4:0]  xkill;
    logic [1:0]  xact;
    logic        xvld;
    logic [31:0] xpc;
  } vec_t;

  // Thread t resets to 0x1000 + 0x100*t; increment 4.
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,2'd0,3'd0,32'h0,    1'b0,2'd0,5'b00000,10'd0, 5'b00000,2'd0,1'b1,32'h1004},
    '{1'b1,1'b0,1'b0,2'd0,3'd0,32'h0,    1'b0,2'd0,5'b00000,10'd0, 5'b00000,2'd0,1'b1,32'h1008},
    '{1'b0,1'b0,1'b0,2'd0,3'd0,32'h0,    1'b0,2'd0,5'b00000,10'd0, 5'b00000,2'd0,1'b1,32'h1008},
    '{1'b0,1'b1,1'b0,2'd0,3'd0,32'h1008, 1'b0,2'd0,5'b00001,10'd0, 5'b00001,2'd1,1'b1,32'h1100},
    '{1'b1,1'b0,1'b0,2'd0,3'd0,32'h0,    1'b0,2'd0,5'b00000,10'd0, 5'b00000,2'd1,1'b1,32'h1104},
    '{1'b1,1'b0,1'b0,2'd0,3'd0,32'h0,    1'b0,2'd0,5'b00000,10'd0, 5'b00000,2'd1,1'b1,32'h1108},
    '{1'b0,1'b0,1'b1,2'd1,3'd2,32'h1100, 1'b0,2'd0,5'b11111,{2'd0,2'd1,2'd1,2'd1,2'd1},
                                                                   5'b00111,2'd2,1'b1,32'h1200},
    '{1'b0,1'b0,1'b0,2'd0,3'd0,32'h0,    1'b1,2'd0,5'b00000,10'd0, 5'b00000,2'd2,1'b1,32'h1200},
    '{1'b0,1'b1,1'b0,2'd0,3'd0,32'h1200, 1'b0,2'd0,5'b00001,{8'd0,2'd2}, 5'b00001,2'd3,1'b1,32'h1300},
    '{1'b0,1'b0,1'b1,2'd3,3'd0,32'h1300, 1'b0,2'd0,5'b00001,{8'd0,2'd3}, 5'b00001,2'd0,1'b1,32'h1008},
    '{1'b0,1'b1,1'b0,2'd0,3'd0,32'h1008, 1'b0,2'd0,5'b00001,10'd0, 5'b00001,2'd0,1'b0,32'h1008},
    '{1'b1,1'b0,1'b0,2'd0,3'd0,32'h0,    1'b0,2'd0,5'b00000,10'd0, 5'b00000,2'd0,1'b0,32'h1008},
    '{1'b0,1'b0,1'b0,2'd0,3'd0,32'h0,    1'b1,2'd1,5'b00000,10'd0, 5'b00000,2'd1,1'b1,32'h1100},
    '{1'b1,1'b0,1'b0,2'd0,3'd0,32'h0,    1'b1,2'd2,5'b00000,10'd0, 5'b00000,2'd1,1'b1,32'h1104}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1, 4, 5: return "R2";
      2:          return "R3";
      3:          return "R4/R7";
      6:          return "R5/R7";
      7:          return "R9/R11";
      8:          return "R4/R7";
      9:          return "R5/R7";
      10, 11:     return "R8";
      12:         return "R6/R8";
      default:    return "R11";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_adv, ic_miss_vld, dc_miss_vld, fill_done_vld;
  logic [31:0] ic_miss_pc, dc_miss_pc;
  logic [1:0]  dc_miss_tid, fill_done_tid;
  logic [2:0]  dc_miss_stg;
  logic [4:0]  stg_vld;
  logic [9:0]  stg_tid;
  logic [1:0]  act_tid;
  logic        fetch_vld;
  logic [31:0] fetch_pc;
  logic [4:0]  kill;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cgts_switch_ctrl u_cgts_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .fetch_adv(fetch_adv),
    .ic_miss_vld(ic_miss_vld), .ic_miss_pc(ic_miss_pc),
    .dc_miss_vld(dc_miss_vld), .dc_miss_tid(dc_miss_tid),
    .dc_miss_stg(dc_miss_stg), .dc_miss_pc(dc_miss_pc),
    .fill_done_vld(fill_done_vld), .fill_done_tid(fill_done_tid),
    .stg_vld(stg_vld), .stg_tid(stg_tid),
    .act_tid(act_tid), .fetch_vld(fetch_vld), .fetch_pc(fetch_pc), .kill(kill)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic adv, input logic ic, input logic [31:0] ipc,
                       input logic dc, input logic [1:0] dtid, input logic [2:0] dstg,
                       input logic [31:0] dpc, input logic done, input logic [1:0] ftid,
                       input logic [4:0] sv, input logic [9:0] st);
    @(negedge clk);
    fetch_adv = adv; ic_miss_vld = ic; ic_miss_pc = ipc;
    dc_miss_vld = dc; dc_miss_tid = dtid; dc_miss_stg = dstg; dc_miss_pc = dpc;
    fill_done_vld = done; fill_done_tid = ftid; stg_vld = sv; stg_tid = st;
    #1;
  endtask

  task automatic after_edge(input string req, input logic [1:0] xa,
                            input logic xv, input logic [31:0] xp);
    @(posedge clk);
    #1;
    chk(req, "act_tid", 32'(act_tid), 32'(xa));
    chk(req, "fetch_vld", 32'(fetch_vld), 32'(xv));
    chk(req, "fetch_pc", fetch_pc, xp);
  endtask

  task automatic chk_reset_state();
    chk("R1", "act_tid", 32'(act_tid), 32'd0);
    chk("R1", "fetch_vld", 32'(fetch_vld), 32'd1);
    chk("R1", "fetch_pc", fetch_pc, 32'h1000);
    chk("R1", "kill", 32'(kill), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1..R11 actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fetch_adv = 0; ic_miss_vld = 0; ic_miss_pc = 0; dc_miss_vld = 0;
    dc_miss_tid = 0; dc_miss_stg = 0; dc_miss_pc = 0; fill_done_vld = 0;
    fill_done_tid = 0; stg_vld = 0; stg_tid = 0;
    repeat (3) @(posedge clk);
    #1;
    chk_reset_state();  // R1
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].adv, TBL[i].ic, TBL[i].mpc, TBL[i].dc, TBL[i].dtid, TBL[i].dstg,
            TBL[i].mpc, TBL[i].done, TBL[i].ftid, TBL[i].svld, TBL[i].stid);
      chk(tag_of(i), "kill", 32'(kill), 32'(TBL[i].xkill));
      after_edge(tag_of(i), TBL[i].xact, TBL[i].xvld, TBL[i].xpc);
    end

    // R10: both miss kinds on thread 1 together; data-miss PC must win.
    drive(1'b0, 1'b1, 32'h1104, 1'b1, 2'd1, 3'd1, 32'h1180, 1'b0, 2'd0,
          5'b00011, {6'd0, 2'd1, 2'd1});
    chk("R10", "kill", 32'(kill), 32'h3);
    after_edge("R10", 2'd2, 1'b1, 32'h1200);
    // R8: thread 2 parks with nobody else ready.
    drive(1'b0, 1'b1, 32'h1200, 1'b0, 2'd0, 3'd0, 32'h0, 1'b0, 2'd0,
          5'b00001, {8'd0, 2'd2});
    chk("R4", "kill", 32'(kill), 32'h1);
    after_edge("R8", 2'd2, 1'b0, 32'h1200);
    // R10: thread 1 resumes at the data-miss address.
    drive(1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 3'd0, 32'h0, 1'b1, 2'd1, 5'b0, 10'd0);
    after_edge("R10", 2'd1, 1'b1, 32'h1180);
    // R10: miss and fill on the same thread in one cycle leave it parked.
    drive(1'b0, 1'b1, 32'h1180, 1'b0, 2'd0, 3'd0, 32'h0, 1'b1, 2'd1,
          5'b00001, {8'd0, 2'd1});
    after_edge("R10", 2'd1, 1'b0, 32'h1180);
    // R8/R7: fill on thread 3 brings it in.
    drive(1'b1, 1'b0, 32'h0, 1'b0, 2'd0, 3'd0, 32'h0, 1'b1, 2'd3, 5'b0, 10'd0);
    after_edge("R8", 2'd3, 1'b1, 32'h1300);

    // R1: asynchronous reset in mid-run.
    drive(1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 3'd0, 32'h0, 1'b0, 2'd0, 5'b0, 10'd0);
    rst_n = 1'b0;
    #1;
    chk_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    // R1: thread 1 reset address is reachable after a fetch miss on thread 0.
    drive(1'b0, 1'b1, 32'h1000, 1'b0, 2'd0, 3'd0, 32'h0, 1'b0, 2'd0, 5'b00001, 10'd0);
    after_edge("R1", 2'd1, 1'b1, 32'h1100);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule